// File: doc/BRIEF.md
# Staggered Doublet Local Coincidence

This block turns two bit vectors, one per detector plane, into a single hit map with twice the granularity of either plane. The two planes carry the same number of readout cells, and cell `i` of plane B is displaced by half a cell to the right of cell `i` of plane A. So every A/B cell pair shares a central overlap, and each cell has one half-cell region that only one plane covers.

Every clock the block takes one vector from each plane. It clears any channel whose mask bit is set, then forms a relaxed coincidence. When both cells of pair `i` fire, the block reports the centre of their overlap. When a cell fires and its partner in the same pair does not, the block reports the edge region that only that plane covers. An edge position that sits next to a reported centre is dropped, so that one track yields one position. A strict input turns the block into a plain AND, which reports centres only.

The result is registered and appears one clock after the inputs are sampled. The block feeds a downstream coincidence matrix. Input phase alignment and readout are outside this block.

Top module: `stag_doublet_coinc`

## Requirements
- R1: While `rst_n` is low, `hit_o` is all zeros after every rising clock edge.
- R2: Odd output index `2i+1` (i = 0..N-1) is set exactly when cell `i` is set and unmasked on both planes.
- R3: A mask bit of 1 in `msk_a_i` or `msk_b_i` removes that channel completely. A vector in which every set input bit is masked gives an all-zero output.
- R4: In relaxed mode (`strict_i` = 0), even output index `2i` is a candidate edge when cell `i` of plane A is alone in its pair, or when cell `i-1` of plane B is alone in its pair.
- R5: A candidate edge at index `2i` is cleared when either odd neighbour (`2i-1` or `2i+1`) is set. No even output bit is ever set next to a set odd output bit.
- R6: With `strict_i` = 1, every even output bit is zero and the odd bits follow R2.
- R7: `hit_o` reflects the inputs sampled at the previous rising edge. All-zero plane inputs give an all-zero output.
- R8: Index 0 can only come from a lone A cell 0, and index `2N` can only come from a lone B cell `N-1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| plane_a_i | input | N | Hit bits of plane A, one per cell |
| plane_b_i | input | N | Hit bits of plane B, shifted half a cell right of A |
| msk_a_i | input | N | 1 disables the matching plane A channel |
| msk_b_i | input | N | 1 disables the matching plane B channel |
| strict_i | input | 1 | 0 selects relaxed coincidence, 1 selects plain AND |
| hit_o | output | 2N+1 | Registered half-cell hit map; odd bits are centres, even bits are edges |

## Verification
The block holds no state except the output register, so a fault shows up one clock after the stimulus that exposes it and never lingers. A wrong pair decode shows as a centre bit on an odd index with only one plane set. A broken suppression path shows as an even bit standing next to an odd bit. A stuck mode or mask path leaves edge bits present in strict mode, or output bits present after fully masked inputs. Random sparse vectors, each compared one cycle later against a bench model, expose such faults within a few cycles.

// File: rtl/ldc_pkg.sv
package ldc_pkg;
    typedef enum logic {
        MODE_RELAXED = 1'b0,
        MODE_STRICT  = 1'b1
    } ldc_mode_e;
endpackage

// File: rtl/ldc_mask.sv
module ldc_mask #(
    parameter int NCELL = 16
) (
    input  logic [NCELL-1:0] raw_i,
    input  logic [NCELL-1:0] msk_i,
    output logic [NCELL-1:0] clean_o
);
    // One gate per channel: a set mask bit silences the channel (R3)
    for (genvar c = 0; c < NCELL; c++) begin : g_ch
        assign clean_o[c] = raw_i[c] & ~msk_i[c];
    end
endmodule

// File: rtl/ldc_pair.sv
module ldc_pair #(
    parameter int NCELL = 16
) (
    input  logic [NCELL-1:0] a_i,
    input  logic [NCELL-1:0] b_i,
    output logic [NCELL-1:0] dbl_o,
    output logic [NCELL-1:0] a_only_o,
    output logic [NCELL-1:0] b_only_o
);
    // Classify each staggered pair: both, A alone, B alone
    for (genvar c = 0; c < NCELL; c++) begin : g_pair
        assign dbl_o[c]    = a_i[c] & b_i[c];
        assign a_only_o[c] = a_i[c] & ~b_i[c];
        assign b_only_o[c] = b_i[c] & ~a_i[c];
    end
endmodule

// File: rtl/ldc_edge.sv
module ldc_edge #(
    parameter int NCELL = 16,
    localparam int OW   = 2 * NCELL + 1
) (
    input  logic [NCELL-1:0] dbl_i,
    input  logic [NCELL-1:0] a_only_i,
    input  logic [NCELL-1:0] b_only_i,
    input  ldc_pkg::ldc_mode_e mode_i,
    output logic [OW-1:0]    pos_o
);
    logic relaxed;
    assign relaxed = (mode_i == ldc_pkg::MODE_RELAXED);

    // Odd slots: overlap centres of each pair (R2)
    for (genvar c = 0; c < NCELL; c++) begin : g_ctr
        assign pos_o[2*c+1] = dbl_i[c];
    end

    // Even slots: edge regions between pairs (R4, R5, R8)
    for (genvar e = 0; e <= NCELL; e++) begin : g_edge
        logic from_a, from_b, near_ctr;
        if (e == 0) begin : g_lo
            assign from_a   = a_only_i[0];
            assign from_b   = 1'b0;
            assign near_ctr = dbl_i[0];
        end else if (e == NCELL) begin : g_hi
            assign from_a   = 1'b0;
            assign from_b   = b_only_i[NCELL-1];
            assign near_ctr = dbl_i[NCELL-1];
        end else begin : g_mid
            assign from_a   = a_only_i[e];
            assign from_b   = b_only_i[e-1];
            assign near_ctr = dbl_i[e] | dbl_i[e-1];
        end
        assign pos_o[2*e] = relaxed & (from_a | from_b) & ~near_ctr;
    end
endmodule

// File: rtl/stag_doublet_coinc.sv
module stag_doublet_coinc #(
    parameter int NCELL = 16,
    localparam int OW   = 2 * NCELL + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCELL-1:0] plane_a_i,
    input  logic [NCELL-1:0] plane_b_i,
    input  logic [NCELL-1:0] msk_a_i,
    input  logic [NCELL-1:0] msk_b_i,
    input  logic             strict_i,
    output logic [OW-1:0]    hit_o
);
    import ldc_pkg::*;

    function automatic logic [OW-1:0] even_sel();
        logic [OW-1:0] m;
        m = '0;
        for (int k = 0; k < OW; k += 2) m[k] = 1'b1;
        return m;
    endfunction
    localparam logic [OW-1:0] EVEN_M = even_sel();

    logic [NCELL-1:0] a_cln, b_cln, dbl, a_only, b_only;
    logic [OW-1:0]    pos_d, hit_q;
    ldc_mode_e        mode;

    assign mode = ldc_mode_e'(strict_i);

    ldc_mask #(.NCELL(NCELL)) mask_a_i (.raw_i(plane_a_i), .msk_i(msk_a_i), .clean_o(a_cln));
    ldc_mask #(.NCELL(NCELL)) mask_b_i (.raw_i(plane_b_i), .msk_i(msk_b_i), .clean_o(b_cln));

    ldc_pair #(.NCELL(NCELL)) pair_i (
        .a_i(a_cln), .b_i(b_cln),
        .dbl_o(dbl), .a_only_o(a_only), .b_only_o(b_only)
    );

    ldc_edge #(.NCELL(NCELL)) edge_i (
        .dbl_i(dbl), .a_only_i(a_only), .b_only_i(b_only),
        .mode_i(mode), .pos_o(pos_d)
    );

    // Output register, one clock of latency (R1, R7)
    always_ff @(posedge clk) begin
        if (!rst_n) hit_q <= '0;
        else        hit_q <= pos_d;
    end

    assign hit_o = hit_q;

    AST_NO_ADJ_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit_q & EVEN_M & ((hit_q << 1) | (hit_q >> 1))) == '0)); // R5
    AST_STRICT_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        strict_i |=> ((hit_o & EVEN_M) == '0)); // R6
    AST_ZERO_IN_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (plane_a_i == '0 && plane_b_i == '0) |=> (hit_o == '0)); // R7
    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ((plane_a_i & ~msk_a_i) == '0 && (plane_b_i & ~msk_b_i) == '0) |=> (hit_o == '0)); // R3
endmodule

// File: tb/stag_doublet_coinc_tb.sv
`timescale 1ns/1ps
module stag_doublet_coinc_tb_top;
    localparam int N  = 16;
    localparam int OW = 2 * N + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pa = '0, pb = '0, ma = '0, mb = '0;
    logic          st = 1'b0;
    logic [OW-1:0] hit;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    stag_doublet_coinc #(.NCELL(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .plane_a_i(pa), .plane_b_i(pb),
        .msk_a_i(ma), .msk_b_i(mb), .strict_i(st), .hit_o(hit)
    );

    function automatic logic [OW-1:0] model(logic [N-1:0] a, logic [N-1:0] b,
                                            logic [N-1:0] xa, logic [N-1:0] xb, logic s);
        logic [N-1:0]  ac, bc;
        logic [OW-1:0] r;
        logic          e;
        ac = a & ~xa;
        bc = b & ~xb;
        r  = '0;
        for (int i = 0; i < N; i++) r[2*i+1] = ac[i] & bc[i];
        if (!s) begin
            for (int i = 0; i <= N; i++) begin
                e = 1'b0;
                if (i < N && ac[i] && !bc[i]) e = 1'b1;
                if (i > 0 && bc[i-1] && !ac[i-1]) e = 1'b1;
                if (i < N && r[2*i+1]) e = 1'b0;
                if (i > 0 && r[2*i-1]) e = 1'b0;
                r[2*i] = e;
            end
        end
        return r;
    endfunction

    task automatic check(string req, logic [OW-1:0] act, logic [OW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Drive at negedge, registered at next posedge, checked at the negedge after
    task automatic apply(string req, logic [N-1:0] a, logic [N-1:0] b,
                         logic [N-1:0] xa, logic [N-1:0] xb, logic s);
        pa = a; pb = b; ma = xa; mb = xb; st = s;
        @(negedge clk);
        check(req, hit, model(a, b, xa, xb, s));
    endtask

    task automatic apply_exp(string req, logic [N-1:0] a, logic [N-1:0] b,
                             logic s, logic [OW-1:0] exp);
        pa = a; pb = b; ma = '0; mb = '0; st = s;
        @(negedge clk);
        check(req, hit, exp);
    endtask

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd20240611);
        pa = 16'hFFFF; pb = 16'h00FF;
        repeat (3) @(negedge clk);
        check("R1 reset", hit, '0);
        rst_n = 1'b1;
        pa = '0; pb = '0;
        @(negedge clk);
        apply_exp("R7 zero in", '0, '0, 1'b0, '0);
        apply_exp("R8 low edge A0", 16'h0001, '0, 1'b0, 33'h1);
        apply_exp("R8 high edge B15", '0, 16'h8000, 1'b0, 33'h1_0000_0000);
        apply_exp("R2 pair3 centre", 16'h0008, 16'h0008, 1'b0, 33'h80);
        apply_exp("R4 A3 alone", 16'h0008, '0, 1'b0, 33'h40);
        apply_exp("R4 B3 alone", '0, 16'h0008, 1'b0, 33'h100);
        apply_exp("R5 A4 next to centre3", 16'h0018, 16'h0008, 1'b0, 33'h80);
        apply_exp("R6 strict single", 16'h0020, '0, 1'b1, '0);
        apply_exp("R6 strict pair", 16'h0021, 16'h0001, 1'b1, 33'h2);
        apply("R3 full mask", 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0);
        apply("R3 mask B keeps A edge", 16'h0004, 16'h0004, '0, 16'h0004, 1'b0);
        apply("R7 all set", 16'hFFFF, 16'hFFFF, '0, '0, 1'b0);
        apply("R4 alternate", 16'hAAAA, 16'h5555, '0, '0, 1'b0);
        for (int n = 0; n < 400; n++) begin
            logic [N-1:0] ra, rb, rma, rmb;
            ra  = N'($urandom & $urandom);
            rb  = N'($urandom & $urandom);
            rma = N'($urandom & $urandom & $urandom);
            rmb = N'($urandom & $urandom & $urandom);
            apply("R2 R4 R5 random", ra, rb, rma, rmb, ($urandom % 8) == 0);
        end
        rst_n = 1'b0;
        pa = 16'h0F0F; pb = 16'h00FF;
        @(negedge clk);
        check("R1 reset again", hit, '0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule